// File: doc/BRIEF.md
# Receiver Acquisition and Hold Sequencer

This block drives the three control lines of a narrowband data demodulator: a level-acquire strobe for the DC-level measurement loop, a timing-acquire strobe for the clock-recovery loop, and a hold line that freezes both loops. It receives a bit-rate tick, a level indication that a receive burst is in progress, an indication that the mean input level has reached its final value, and a hold request. The hold request is raised during a fade, or while the local station transmits on a shared continuous channel.

When a burst starts, the block waits for the settled indication. It then raises both acquire strobes together for a programmed number of bit ticks and drops into tracking. A hold request during tracking freezes the loops. When the request is released after a short hold, tracking resumes directly. After a long hold, only the level loop is re-acquired and bit timing is kept. Dropping the receive indication returns the block to idle from any state.

Top module: `rx_acq_seq`

## Requirements
- R1: After reset, and one cycle after `rx_active_i` is sampled low, `lvl_acq_o`, `tim_acq_o`, `hold_o` and `locked_o` are all 0.
- R2: Neither acquire strobe rises while `settled_i` is low. The strobes rise in the cycle after the clock edge that samples `settled_i` high with `hold_req_i` low.
- R3: A first acquisition keeps `lvl_acq_o` and `tim_acq_o` high together until N ticks of `bit_tick_i` have been sampled during the pulse, where N is `acq_len_i`, raised to 8 when `acq_len_i` is below 8. With a tick every cycle, the strobes are high for N cycles.
- R4: `locked_o` is high for exactly one cycle each time tracking is entered: after an acquire pulse ends, or when a hold is released into tracking. It is never high together with an acquire strobe.
- R5: While tracking, a hold request sampled high raises `hold_o` in the next cycle. `hold_o` stays high as long as the request stays high.
- R6: While an acquire strobe is high, `hold_o` stays 0. A hold request during a first acquisition drops both strobes and restarts the wait for settling, with a full-length pulse afterwards. A hold request during a level-only re-acquisition is ignored until that pulse ends.
- R7: When a hold is released after fewer bit ticks than `long_hold_i`, tracking resumes and no acquire strobe is raised.
- R8: When a hold is released after at least `long_hold_i` bit ticks, `lvl_acq_o` alone is pulsed for N ticks and `tim_acq_o` stays 0.
- R9: The hold-duration count saturates at 1023. With `long_hold_i` = 1023, a hold of more than 1024 ticks still triggers the level-only re-acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe per received bit period |
| rx_active_i | input | 1 | High while a receive burst is in progress |
| settled_i | input | 1 | High when the mean input level is near its final value |
| hold_req_i | input | 1 | Fade or local-transmit hold request, active high |
| acq_len_i | input | 6 | Acquire pulse length in bit ticks (values below 8 act as 8) |
| long_hold_i | input | 10 | Hold length in bit ticks from which a level re-acquisition follows |
| lvl_acq_o | output | 1 | Level-measurement acquire strobe |
| tim_acq_o | output | 1 | Clock-recovery acquire strobe |
| hold_o | output | 1 | Freeze of both loops |
| locked_o | output | 1 | One-cycle strobe on entry into tracking |

## Verification
The hardest case to reach from the ports is the saturated hold-duration counter. Reaching it needs a burst that is fully acquired, then a hold request kept high for more than a thousand bit ticks, with the threshold programmed at the counter's ceiling. The bench acquires with a tick every cycle, keeps the hold request high for 1100 cycles with `long_hold_i` at 1023, and expects a level-only pulse after release. A 500-cycle hold at the same threshold is run first and must return straight to tracking. A second awkward case is a hold request that lands in the middle of a first acquisition. The bench raises it three ticks into the pulse and checks that a full-length pulse follows once the request clears.

// File: rtl/rx_acq_pkg.sv
package rx_acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACQ,
    ST_TRACK,
    ST_HOLD,
    ST_REACQ
  } seq_state_e;
endpackage

// File: rtl/rx_acq_tick_cnt.sv
module rx_acq_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rx_acq_fsm.sv
module rx_acq_fsm
  import rx_acq_pkg::*;
#(
  parameter int ACQ_W  = 6,
  parameter int HOLD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              rx_active_i,
  input  logic              settled_i,
  input  logic              hold_req_i,
  input  logic [ACQ_W-1:0]  acq_len_i,
  input  logic [HOLD_W-1:0] long_hold_i,
  input  logic [ACQ_W-1:0]  acq_cnt_i,
  input  logic [HOLD_W-1:0] hold_cnt_i,
  output seq_state_e        state_o,
  output seq_state_e        prev_o
);
  logic       acq_done;
  seq_state_e state_d;

  // pulse ends on the tick that completes the programmed count
  assign acq_done = bit_tick_i && (acq_cnt_i == acq_len_i - 1'b1);

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE:  state_d = ST_WAIT;
      ST_WAIT:  if (settled_i && !hold_req_i) state_d = ST_ACQ;
      ST_ACQ: begin
        if (hold_req_i)    state_d = ST_WAIT;
        else if (acq_done) state_d = ST_TRACK;
      end
      ST_TRACK: if (hold_req_i) state_d = ST_HOLD;
      ST_HOLD:  if (!hold_req_i)
                  state_d = (hold_cnt_i >= long_hold_i) ? ST_REACQ : ST_TRACK;
      ST_REACQ: if (acq_done) state_d = ST_TRACK;
      default:  state_d = ST_IDLE;
    endcase
    if (!rx_active_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      prev_o  <= ST_IDLE;
    end else begin
      state_o <= state_d;
      prev_o  <= state_o;
    end
  end
endmodule

// File: rtl/rx_acq_seq.sv
module rx_acq_seq
  import rx_acq_pkg::*;
#(
  parameter int ACQ_W   = 6,
  parameter int HOLD_W  = 10,
  parameter int ACQ_MIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              rx_active_i,
  input  logic              settled_i,
  input  logic              hold_req_i,
  input  logic [ACQ_W-1:0]  acq_len_i,
  input  logic [HOLD_W-1:0] long_hold_i,
  output logic              lvl_acq_o,
  output logic              tim_acq_o,
  output logic              hold_o,
  output logic              locked_o
);
  localparam logic [ACQ_W-1:0] LEN_FLOOR = ACQ_W'(ACQ_MIN);

  seq_state_e        state, prev;
  logic [ACQ_W-1:0]  acq_len_eff, acq_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic              in_pulse, in_hold;

  assign acq_len_eff = (acq_len_i < LEN_FLOOR) ? LEN_FLOOR : acq_len_i;
  assign in_pulse    = (state == ST_ACQ) || (state == ST_REACQ);
  assign in_hold     = (state == ST_HOLD);

  rx_acq_tick_cnt #(.W(ACQ_W)) u_acq_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_pulse),
    .inc_i  (in_pulse && bit_tick_i),
    .cnt_o  (acq_cnt)
  );

  rx_acq_tick_cnt #(.W(HOLD_W)) u_hold_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_hold),
    .inc_i  (in_hold && bit_tick_i),
    .cnt_o  (hold_cnt)
  );

  rx_acq_fsm #(.ACQ_W(ACQ_W), .HOLD_W(HOLD_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_tick_i  (bit_tick_i),
    .rx_active_i (rx_active_i),
    .settled_i   (settled_i),
    .hold_req_i  (hold_req_i),
    .acq_len_i   (acq_len_eff),
    .long_hold_i (long_hold_i),
    .acq_cnt_i   (acq_cnt),
    .hold_cnt_i  (hold_cnt),
    .state_o     (state),
    .prev_o      (prev)
  );

  assign lvl_acq_o = in_pulse;
  assign tim_acq_o = (state == ST_ACQ);
  assign hold_o    = in_hold;
  assign locked_o  = (state == ST_TRACK) && (prev != ST_TRACK);
endmodule

// File: rtl/rx_acq_seq_chk.sv
module rx_acq_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_active_i,
  input logic settled_i,
  input logic hold_req_i,
  input logic lvl_acq_o,
  input logic tim_acq_o,
  input logic hold_o,
  input logic locked_o
);
  // R1
  idle_on_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_active_i |=> !(lvl_acq_o || tim_acq_o || hold_o || locked_o));

  // R2
  settle_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tim_acq_o) |-> $past(settled_i));

  // R3
  tim_within_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tim_acq_o |-> lvl_acq_o);

  // R4
  locked_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> !locked_o);

  // R4
  locked_not_acq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !(lvl_acq_o || tim_acq_o));

  // R5
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && hold_req_i && rx_active_i) |=> hold_o);

  // R6
  hold_vs_acq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_o && lvl_acq_o));

  // R8
  lvl_only_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lvl_acq_o) && !tim_acq_o) |-> $past(hold_o));
endmodule

bind rx_acq_seq rx_acq_seq_chk u_rx_acq_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_active_i (rx_active_i),
  .settled_i   (settled_i),
  .hold_req_i  (hold_req_i),
  .lvl_acq_o   (lvl_acq_o),
  .tim_acq_o   (tim_acq_o),
  .hold_o      (hold_o),
  .locked_o    (locked_o)
);

// File: tb/rx_acq_seq_test.sv
module rx_acq_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, rx_active = 1'b0, settled = 1'b0, hold_req = 1'b0;
  logic [5:0] acq_len = 6'd16;
  logic [9:0] long_hold = 10'd256;
  logic       lvl_acq, tim_acq, hold, locked;

  int checks = 0, fails = 0;
  int tick_div = 1, tick_ph = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_acq_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(bit_tick), .rx_active_i(rx_active),
    .settled_i(settled), .hold_req_i(hold_req), .acq_len_i(acq_len),
    .long_hold_i(long_hold), .lvl_acq_o(lvl_acq), .tim_acq_o(tim_acq),
    .hold_o(hold), .locked_o(locked)
  );

  // {acq_len, tick period, expected high cycles}
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{16, 1, 16}, '{8, 1, 8}, '{3, 1, 8}, '{0, 1, 8}, '{63, 1, 63}, '{10, 3, 29}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    bit_tick = (tick_ph == tick_div - 1);
  endtask

  task automatic raise_settled();
    cyc();
    settled = 1'b1;
    tick_ph = 0;
    bit_tick = (tick_div == 1);
  endtask

  // measures strobe length; returns high count, checks lvl==tim (or tim low)
  task automatic measure(input bit lvl_only, output int n, output int lk);
    n = 0; lk = 0;
    for (int i = 0; i < 400; i++) begin
      cyc();
      if (lvl_acq) begin
        n++;
        if (tim_acq != !lvl_only) chk(lvl_only ? "R8" : "R3", tim_acq, !lvl_only);
      end else if (n > 0 || i > 2) begin
        lk = locked;
        break;
      end
    end
  endtask

  task automatic acquire_to_track();
    int n, lk;
    rx_active = 1'b0; settled = 1'b0; hold_req = 1'b0; tick_div = 1;
    cyc();
    rx_active = 1'b1;
    cyc(); cyc();
    raise_settled();
    measure(1'b0, n, lk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, lk;
    cyc(); cyc();
    // R1 reset state
    chk("R1", {lvl_acq, tim_acq, hold, locked}, 0);
    rst_n = 1'b1;
    cyc();
    chk("R1", {lvl_acq, tim_acq, hold, locked}, 0);

    // vector table: settle gating and pulse length
    for (int v = 0; v < NV; v++) begin
      rx_active = 1'b0; settled = 1'b0; hold_req = 1'b0;
      acq_len = 6'(VEC[v][0]); tick_div = VEC[v][1];
      cyc();
      rx_active = 1'b1;
      for (int k = 0; k < 5; k++) begin
        cyc();
        chk("R2", {lvl_acq, tim_acq}, 0);
      end
      raise_settled();
      cyc();
      chk("R2", {lvl_acq, tim_acq}, 2'b11);
      measure(1'b0, n, lk);
      chk("R3", n + 1, VEC[v][2]);
      chk("R4", lk, 1);
      cyc();
      chk("R4", locked, 0);
    end

    // R1 loss of receive indication while tracking
    acq_len = 6'd16; tick_div = 1;
    acquire_to_track();
    rx_active = 1'b0;
    cyc();
    chk("R1", {lvl_acq, tim_acq, hold, locked}, 0);

    // R5/R7 short hold
    acquire_to_track();
    cyc();
    hold_req = 1'b1;
    cyc();
    chk("R5", hold, 1);
    repeat (9) cyc();
    chk("R5", hold, 1);
    hold_req = 1'b0;
    cyc();
    chk("R7", {lvl_acq, tim_acq, hold}, 0);
    chk("R4", locked, 1);
    cyc();
    chk("R7", {lvl_acq, tim_acq}, 0);

    // R8 long hold -> level only, plus R6 hold ignored during re-acquire
    hold_req = 1'b1;
    repeat (300) cyc();
    hold_req = 1'b0;
    cyc();
    chk("R8", {lvl_acq, tim_acq, hold}, 3'b100);
    hold_req = 1'b1;
    cyc();
    chk("R6", {lvl_acq, hold}, 2'b10);
    hold_req = 1'b0;
    measure(1'b1, n, lk);
    chk("R8", n + 2, 16);

    // R6 hold mid-acquisition restarts settle wait
    rx_active = 1'b0; settled = 1'b0; cyc();
    rx_active = 1'b1; cyc();
    raise_settled();
    repeat (4) cyc();
    chk("R6", tim_acq, 1);
    hold_req = 1'b1;
    cyc();
    chk("R6", {lvl_acq, tim_acq, hold}, 0);
    repeat (3) cyc();
    chk("R6", {lvl_acq, tim_acq, hold}, 0);
    hold_req = 1'b0;
    cyc();
    chk("R6", tim_acq, 1);
    measure(1'b0, n, lk);
    chk("R6", n + 1, 16);

    // R9 saturation with threshold at ceiling
    long_hold = 10'd1023;
    hold_req = 1'b1;
    repeat (500) cyc();
    hold_req = 1'b0;
    cyc();
    chk("R9", {lvl_acq, tim_acq, locked}, 3'b001);
    hold_req = 1'b1;
    repeat (1100) cyc();
    hold_req = 1'b0;
    cyc();
    chk("R9", {lvl_acq, tim_acq, hold}, 3'b100);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule